// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small processor core. The core's decoder passes it a one-cycle strobe for the sleep instruction and another for the watchdog-clear instruction. The watchdog counter passes a time-out strobe, and the pin logic passes an external reset strobe. Each interrupt source supplies a flag and an enable bit, and there is a global interrupt enable. From these inputs the block drives the oscillator enable and the clear pulses for the watchdog counter and its postscaler. It also keeps two status flags that software reads to learn why the core reset or woke up.

A sleep instruction is skipped when any enabled interrupt source already has its flag set: nothing changes and the core carries on. Otherwise the block clears the watchdog, records that sleep was executed and stops the oscillator. It then holds the already fetched next instruction until a wake event arrives. An external reset ends sleep with a core reset. A watchdog time-out or an enabled interrupt instead passes through a one-cycle WAKE state with the oscillator back on. The block then signals the core to resume, and tells it whether to branch to the interrupt vector after that next instruction.

The status flag `st_nosleep` reads 1 when no sleep has executed since the last power-up or watchdog clear. The flag `st_notmo` reads 0 after a watchdog time-out.

Top module: `slpwk_ctrl`

## Requirements
- R1: A sleep strobe in RUN with no enabled interrupt pending, no external reset and no time-out produces these values after the next clock edge: `osc_en`=0, `wdt_clr`=1, `post_clr`=1, `st_nosleep`=0, `st_notmo`=1 and `fetch_hold`=1. The oscillator stays off for as long as the block sleeps.
- R2: After a synchronous power-up reset `osc_en`, `st_nosleep` and `st_notmo` are 1. `wdt_clr`, `post_clr`, `core_rst`, `resume`, `take_vec` and `fetch_hold` are 0, and `jump_pc` is 0.
- R3: A watchdog time-out while asleep clears `st_notmo` and turns `osc_en` on after one edge. One edge later it gives `resume`=1 with `take_vec`=0, and `st_nosleep` stays 0.
- R4: While asleep, the block wakes (`osc_en`=1 after one edge) when some source i has both `irq_flag[i]` and `irq_en[i]` at 1. A flag whose enable is 0 does not wake it. An interrupt wake leaves `st_nosleep`=0 and `st_notmo`=1.
- R5: The global enable `gie` has no say in whether the block wakes. When the wake is caused by an interrupt, `gie` is sampled at that wake and appears on `take_vec` together with `resume`. `jump_pc` equals parameter VEC (default 0x0004) while `take_vec` is 1 and is 0 otherwise. A time-out wake always gives `take_vec`=0.
- R6: A sleep strobe while an enabled interrupt is pending has no effect. `osc_en` stays 1, no clear pulse is issued, `fetch_hold` stays 0 and both status flags keep their values.
- R7: `resume` is a one-cycle pulse issued in the cycle after WAKE is entered. `fetch_hold` drops to 0 in that same cycle.
- R8: An external reset in any state gives, after one edge, `core_rst`=1, `osc_en`=1, `fetch_hold`=0 and no `resume`. Both status flags are left unchanged.
- R9: A watchdog time-out in RUN gives, after one edge, `core_rst`=1, `st_notmo`=0 and `st_nosleep`=1. `core_rst` lasts one cycle.
- R10: A watchdog-clear strobe in RUN pulses `wdt_clr` and `post_clr` for one cycle and sets both status flags to 1.
- R11: When several strobes arrive in the same cycle, the external reset wins over the time-out. The time-out wins over the sleep strobe, and the sleep strobe wins over the watchdog-clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_op | input | 1 | Sleep instruction executing (one cycle) |
| clrwdt_op | input | 1 | Watchdog-clear instruction executing (one cycle) |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| ext_rst | input | 1 | External reset request strobe |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | NSRC | Per-source interrupt flags |
| irq_en | input | NSRC | Per-source interrupt enables |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| post_clr | output | 1 | Watchdog postscaler clear pulse |
| st_nosleep | output | 1 | 1 = no sleep executed since power-up or watchdog clear |
| st_notmo | output | 1 | 0 = a watchdog time-out occurred |
| core_rst | output | 1 | Core reset request pulse |
| resume | output | 1 | Resume-execution pulse after a wake |
| take_vec | output | 1 | With resume: branch to vector after next instruction |
| jump_pc | output | PC_W | Vector address while take_vec is 1, else 0 |
| fetch_hold | output | 1 | Hold the prefetched next instruction |

## Verification
The bench aims at the race between a pending interrupt and a sleep strobe. If pending interrupts were checked only after the sleep started, the block would clear the watchdog and sleep flag and then wake at once, where it should have skipped the instruction. A flag with its enable cleared is applied while asleep, and a block that ignored the enables would wake early. The wake path is run with the global enable both clear and set, to catch a block that waits for the global enable before waking or that drops the vector request. Simultaneous external reset, time-out and interrupt are applied while asleep, which exposes a wrong priority through a stray `resume` or a cleared time-out flag.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } slpwk_state_e;
endpackage

// File: rtl/slpwk_pending.sv
module slpwk_pending #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  output logic            pend
);
  logic [NSRC-1:0] armed;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign armed[g] = irq_flag[g] & irq_en[g];
    end
  endgenerate

  assign pend = |armed;
endmodule

// File: rtl/slpwk_status.sv
module slpwk_status (
  input  logic clk,
  input  logic rst,
  input  logic ev_sleep,
  input  logic ev_clr,
  input  logic ev_tmo_run,
  input  logic ev_tmo_slp,
  output logic st_nosleep,
  output logic st_notmo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_nosleep <= 1'b1;
      st_notmo   <= 1'b1;
    end else if (ev_tmo_run) begin
      st_nosleep <= 1'b1;
      st_notmo   <= 1'b0;
    end else if (ev_tmo_slp) begin
      st_notmo   <= 1'b0;
    end else if (ev_sleep) begin
      st_nosleep <= 1'b0;
      st_notmo   <= 1'b1;
    end else if (ev_clr) begin
      st_nosleep <= 1'b1;
      st_notmo   <= 1'b1;
    end
  end

  AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ev_sleep |=> (!st_nosleep && st_notmo)); // R1
  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ev_tmo_run || ev_tmo_slp) |=> !st_notmo); // R3
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ev_clr |=> (st_nosleep && st_notmo)); // R10
endmodule

// File: rtl/slpwk_seq.sv
module slpwk_seq
  import slpwk_pkg::*;
#(
  parameter int          PC_W = 13,
  parameter logic [PC_W-1:0] VEC = 13'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_op,
  input  logic            clrwdt_op,
  input  logic            wdt_tmo,
  input  logic            ext_rst,
  input  logic            gie,
  input  logic            pend,
  output logic            ev_sleep,
  output logic            ev_clr,
  output logic            ev_tmo_run,
  output logic            ev_tmo_slp,
  output logic            osc_en,
  output logic            wdt_clr,
  output logic            post_clr,
  output logic            core_rst,
  output logic            resume,
  output logic            take_vec,
  output logic [PC_W-1:0] jump_pc,
  output logic            fetch_hold
);
  slpwk_state_e st;
  logic         vec_lat;
  logic         in_run, in_slp, quiet;

  assign in_run     = (st == ST_RUN);
  assign in_slp     = (st == ST_SLEEP);
  assign quiet      = !ext_rst && !wdt_tmo;
  assign ev_tmo_run = in_run && !ext_rst && wdt_tmo;
  assign ev_tmo_slp = in_slp && !ext_rst && wdt_tmo;
  assign ev_sleep   = in_run && quiet && sleep_op && !pend;
  assign ev_clr     = in_run && quiet && !sleep_op && clrwdt_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      osc_en     <= 1'b1;
      wdt_clr    <= 1'b0;
      post_clr   <= 1'b0;
      core_rst   <= 1'b0;
      resume     <= 1'b0;
      take_vec   <= 1'b0;
      jump_pc    <= '0;
      fetch_hold <= 1'b0;
      vec_lat    <= 1'b0;
    end else begin
      wdt_clr  <= ev_sleep || ev_clr;
      post_clr <= ev_sleep || ev_clr;
      core_rst <= ext_rst || ev_tmo_run;
      resume   <= 1'b0;
      take_vec <= 1'b0;
      jump_pc  <= '0;
      if (ext_rst) begin
        st         <= ST_RUN;
        osc_en     <= 1'b1;
        fetch_hold <= 1'b0;
      end else begin
        case (st)
          ST_RUN: begin
            if (ev_sleep) begin
              st         <= ST_SLEEP;
              osc_en     <= 1'b0;
              fetch_hold <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (wdt_tmo) begin
              st      <= ST_WAKE;
              osc_en  <= 1'b1;
              vec_lat <= 1'b0;
            end else if (pend) begin
              st      <= ST_WAKE;
              osc_en  <= 1'b1;
              vec_lat <= gie;
            end
          end
          ST_WAKE: begin
            st         <= ST_RUN;
            resume     <= 1'b1;
            take_vec   <= vec_lat;
            jump_pc    <= vec_lat ? VEC : '0;
            fetch_hold <= 1'b0;
          end
          default: st <= ST_RUN;
        endcase
      end
    end
  end

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (in_run && sleep_op && !pend && !ext_rst && !wdt_tmo)
      |=> (!osc_en && wdt_clr && post_clr && fetch_hold)); // R1
  AST_OSC_OFF_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (st == ST_SLEEP)); // R1
  AST_NOP_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (in_run && sleep_op && pend && !ext_rst && !wdt_tmo)
      |=> (osc_en && !wdt_clr && !fetch_hold)); // R6
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
    (in_slp && pend && !ext_rst && !wdt_tmo) |=> (osc_en && st == ST_WAKE)); // R4
  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume); // R7
  AST_VEC_WITH_RESUME: assert property (@(posedge clk) disable iff (rst)
    take_vec |-> (resume && jump_pc == VEC)); // R5
  AST_EXT_RESET: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> (core_rst && osc_en && !resume && !fetch_hold)); // R8
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl #(
  parameter int              NSRC = 4,
  parameter int              PC_W = 13,
  parameter logic [PC_W-1:0] VEC  = 13'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_op,
  input  logic            clrwdt_op,
  input  logic            wdt_tmo,
  input  logic            ext_rst,
  input  logic            gie,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  output logic            osc_en,
  output logic            wdt_clr,
  output logic            post_clr,
  output logic            st_nosleep,
  output logic            st_notmo,
  output logic            core_rst,
  output logic            resume,
  output logic            take_vec,
  output logic [PC_W-1:0] jump_pc,
  output logic            fetch_hold
);
  logic pend;
  logic ev_sleep, ev_clr, ev_tmo_run, ev_tmo_slp;

  slpwk_pending #(.NSRC(NSRC)) u_pend (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .pend     (pend)
  );

  slpwk_seq #(.PC_W(PC_W), .VEC(VEC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .sleep_op   (sleep_op),
    .clrwdt_op  (clrwdt_op),
    .wdt_tmo    (wdt_tmo),
    .ext_rst    (ext_rst),
    .gie        (gie),
    .pend       (pend),
    .ev_sleep   (ev_sleep),
    .ev_clr     (ev_clr),
    .ev_tmo_run (ev_tmo_run),
    .ev_tmo_slp (ev_tmo_slp),
    .osc_en     (osc_en),
    .wdt_clr    (wdt_clr),
    .post_clr   (post_clr),
    .core_rst   (core_rst),
    .resume     (resume),
    .take_vec   (take_vec),
    .jump_pc    (jump_pc),
    .fetch_hold (fetch_hold)
  );

  slpwk_status u_status (
    .clk        (clk),
    .rst        (rst),
    .ev_sleep   (ev_sleep),
    .ev_clr     (ev_clr),
    .ev_tmo_run (ev_tmo_run),
    .ev_tmo_slp (ev_tmo_slp),
    .st_nosleep (st_nosleep),
    .st_notmo   (st_notmo)
  );

  AST_ASLEEP_HOLDS_FETCH: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (fetch_hold && !resume)); // R1
  AST_TMO_RUN_RESETS: assert property (@(posedge clk) disable iff (rst)
    (wdt_tmo && !ext_rst && osc_en && !fetch_hold) |=> (core_rst && !st_notmo && st_nosleep)); // R9
endmodule

// File: tb/slpwk_ctrl_test.sv
module slpwk_ctrl_test;
  localparam int NSRC = 4;
  localparam int PC_W = 13;
  localparam logic [9:0] ALL = 10'h3FF;

  logic clk = 1'b0;
  logic rst;
  logic sleep_op, clrwdt_op, wdt_tmo, ext_rst, gie;
  logic [NSRC-1:0] irq_flag, irq_en;
  logic osc_en, wdt_clr, post_clr, st_nosleep, st_notmo;
  logic core_rst, resume, take_vec, fetch_hold;
  logic [PC_W-1:0] jump_pc;

  always #10 clk = ~clk;

  slpwk_ctrl #(.NSRC(NSRC), .PC_W(PC_W), .VEC(13'h0004)) uut (
    .clk(clk), .rst(rst), .sleep_op(sleep_op), .clrwdt_op(clrwdt_op),
    .wdt_tmo(wdt_tmo), .ext_rst(ext_rst), .gie(gie),
    .irq_flag(irq_flag), .irq_en(irq_en),
    .osc_en(osc_en), .wdt_clr(wdt_clr), .post_clr(post_clr),
    .st_nosleep(st_nosleep), .st_notmo(st_notmo), .core_rst(core_rst),
    .resume(resume), .take_vec(take_vec), .jump_pc(jump_pc),
    .fetch_hold(fetch_hold)
  );

  // observed bits: osc wclr pclr nosleep notmo crst resume tvec hold jp_is_vec
  logic [9:0] obs;
  assign obs = {osc_en, wdt_clr, post_clr, st_nosleep, st_notmo, core_rst,
                resume, take_vec, fetch_hold, (jump_pc == 13'h0004)};

  typedef struct {
    int         cyc;
    logic [9:0] mask;
    logic [9:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int d, logic [9:0] m, logic [9:0] v, string r);
    exp_t e;
    e.cyc = cyc + d; e.mask = m; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops items due this cycle and compares
  always @(negedge clk) begin
    if (!done) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          n_cmp++;
          if ((obs & q[i].mask) != (q[i].val & q[i].mask)) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                     q[i].req, cyc, obs & q[i].mask, q[i].val & q[i].mask, q[i].mask);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; sleep_op = 0; clrwdt_op = 0; wdt_tmo = 0; ext_rst = 0; gie = 0;
    irq_flag = '0; irq_en = '0;
    repeat (3) tick();
    expect_at(1, ALL, 10'b1001100000, "R2");
    tick(); rst = 0;
    tick();

    // watchdog clear in RUN
    clrwdt_op = 1;
    expect_at(1, 10'b0111110000, 10'b0111100000, "R10");
    expect_at(2, 10'b0110000000, 10'b0000000000, "R10");
    tick(); clrwdt_op = 0; tick();

    // time-out while running
    wdt_tmo = 1;
    expect_at(1, 10'b1001110000, 10'b1001010000, "R9");
    tick(); wdt_tmo = 0;
    expect_at(1, 10'b0000010000, 10'b0, "R9");
    tick();
    clrwdt_op = 1;
    expect_at(1, 10'b0000100000, 10'b0000100000, "R10");
    tick(); clrwdt_op = 0; tick();

    // plain sleep
    sleep_op = 1;
    expect_at(1, ALL, 10'b0110100010, "R1");
    tick(); sleep_op = 0;
    expect_at(1, 10'b1110000010, 10'b0000000010, "R1");
    tick();

    // flag without enable must not wake
    irq_flag = 4'b0010; irq_en = 4'b0001;
    expect_at(1, 10'b1000000010, 10'b0000000010, "R4");
    tick(); tick();

    // enabled flag wakes, gie clear
    irq_en = 4'b0011; gie = 0;
    expect_at(1, 10'b1000001010, 10'b1000000010, "R4");
    expect_at(2, 10'b0001101111, 10'b0000101000, "R7");
    tick(); irq_flag = '0; irq_en = '0;
    tick();
    expect_at(1, 10'b0000001000, 10'b0, "R7");
    tick();

    // sleep skipped with enabled pending interrupt
    clrwdt_op = 1; tick(); clrwdt_op = 0;
    irq_flag = 4'b0001; irq_en = 4'b0001; gie = 1; sleep_op = 1;
    expect_at(1, 10'b1111100010, 10'b1001100000, "R6");
    tick(); sleep_op = 0; irq_flag = '0; irq_en = '0;
    expect_at(1, 10'b1000000010, 10'b1000000000, "R6");
    tick();

    // interrupt arriving after sleep, gie set: vector taken
    sleep_op = 1; gie = 1;
    tick(); sleep_op = 0;
    irq_flag = 4'b1000; irq_en = 4'b1000;
    expect_at(1, 10'b1000000010, 10'b1000000010, "R5");
    expect_at(2, 10'b0000001111, 10'b0000001101, "R5");
    tick(); irq_flag = '0; irq_en = '0;
    tick();
    expect_at(1, 10'b0000001101, 10'b0, "R5");
    tick();

    // watchdog wake: no vector even with gie set
    sleep_op = 1;
    tick(); sleep_op = 0; wdt_tmo = 1;
    expect_at(1, 10'b1001100010, 10'b1000000010, "R3");
    expect_at(2, 10'b0001101100, 10'b0000001000, "R3");
    tick(); wdt_tmo = 0; tick(); tick();

    // external reset during sleep beats time-out and interrupt
    clrwdt_op = 1; tick(); clrwdt_op = 0;
    sleep_op = 1; gie = 0;
    tick(); sleep_op = 0;
    ext_rst = 1; wdt_tmo = 1; irq_flag = 4'b0001; irq_en = 4'b0001;
    expect_at(1, ALL, 10'b1000110000, "R8 R11");
    expect_at(2, 10'b0000011000, 10'b0, "R11");
    tick(); ext_rst = 0; wdt_tmo = 0; irq_flag = '0; irq_en = '0;
    tick(); tick();

    // external reset while running keeps status
    ext_rst = 1;
    expect_at(1, 10'b1001110010, 10'b1000110000, "R8");
    tick(); ext_rst = 0; tick();

    // sleep wins over watchdog clear
    sleep_op = 1; clrwdt_op = 1;
    expect_at(1, 10'b1001100010, 10'b0000100010, "R11");
    tick(); sleep_op = 0; clrwdt_op = 0;
    irq_flag = 4'b0100; irq_en = 4'b0100;
    tick(); irq_flag = '0; irq_en = '0;
    tick(); tick();

    // time-out wins over sleep in RUN
    wdt_tmo = 1; sleep_op = 1;
    expect_at(1, 10'b1001110010, 10'b1001010000, "R11");
    tick(); wdt_tmo = 0; sleep_op = 0;
    repeat (3) tick();

    done = 1;
    summary();
    $finish;
  end
endmodule